// File: doc/BRIEF.md
# General-purpose I/O port with per-line interrupts

This block is a bank of general-purpose I/O lines behind an APB slave port. Every line can be turned into an output or left as an input on its own, and its driven value is changed by writing ones to a set address or a clear address. Lines that are not named in a write keep their value. Each input passes through a two-flop synchroniser before software reads it back and before any interrupt logic sees it.

Every input can also raise an interrupt. Per line, software picks level or edge sensing, the active polarity, and an optional both-edges mode. Each line has its own enable. Level interrupts follow the synchronised pin. Edge interrupts are caught in a pending latch that holds until software writes a one to the line's bit at the interrupt address. A read of that same address returns the vector of active interrupts. One registered output carries the OR of all active lines to the interrupt controller.

Every control field uses a pair of write-one addresses: one sets bits and the other clears them. A read at either address of the pair returns the current field. APB transfers finish with no wait states.

Top module: `gpio_apb_irq`

## Requirements
- R1: The direction field is set at offset 0x10 and cleared at offset 0x14, with one bit per line where 1 means output. The field is driven on `pin_oe`. A written 1 bit changes only its own line, and a 0 bit changes nothing.
- R2: The output value is set at offset 0x08 and cleared at offset 0x0C, and it can be read at offset 0x04. It is driven on `pin_out`. A written 1 bit changes only its own line, and a 0 bit changes nothing.
- R3: Offset 0x00 reads the input pins after two flip-flop stages on `clk`. Interrupt detection uses the same synchronised value.
- R4: The sense-mode field is set at offset 0x18, where 1 means edge sensing, and cleared at offset 0x1C, where 0 means level sensing. A read at either address returns the field.
- R5: The polarity field is set at offset 0x20 and cleared at offset 0x24. A value of 1 selects a high level or a rising edge, and 0 selects a low level or a falling edge.
- R6: The both-edges field is set at offset 0x28 and cleared at offset 0x2C. When a line's bit is 1 and the line is in edge mode, a rising edge and a falling edge both latch it pending, whatever its polarity.
- R7: The interrupt enable is set at offset 0x30 and cleared at offset 0x34. A disabled line does not latch edges, does not appear in the status vector, and does not drive `irq_out`.
- R8: A level-mode line is active while its synchronised input equals its polarity bit. Writing its bit at offset 0x38 leaves it active.
- R9: An edge-mode line latches pending when its selected edge is seen. It stays pending until a 1 is written to its bit at offset 0x38, even after the pin returns to its previous level.
- R10: A read at offset 0x38 returns the active vector: enabled lines that are pending in edge mode or matching in level mode. `irq_out` is a registered OR of that vector.
- R11: If an edge is detected in the same cycle that a clear write names that line, the line stays pending.
- R12: After a synchronous reset, all lines are inputs, outputs are 0, every field and every pending bit is 0, and `irq_out` is 0. Every transfer has `pready` high and `pslverr` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write, 1 for write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered in the setup phase |
| pready | output | 1 | Always high, so there are no wait states |
| pslverr | output | 1 | Always low |
| pin_in | input | NUM_LINES | Asynchronous pin inputs |
| pin_out | output | NUM_LINES | Driven output values |
| pin_oe | output | NUM_LINES | Output enable per line |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the collision between an edge and a clear write. The edge has to reach the pending logic in exactly the cycle when the access phase of a clear write to the interrupt address completes. From the pin, that takes two synchroniser stages plus one cycle for the detector. The stimulus therefore changes the pin on a falling clock edge and starts the APB setup phase on the next falling edge. The write then lands in the cycle where the edge is detected. The same write also clears a second line that is already pending, so a single read shows both that the clear works and that the new edge wins.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  localparam int BUS_W = 32;

  // Word index inside the register window (byte offset / 4).
  typedef enum logic [3:0] {
    RI_PIN_IN   = 4'd0,
    RI_OUT_VAL  = 4'd1,
    RI_OUT_SET  = 4'd2,
    RI_OUT_CLR  = 4'd3,
    RI_DIR_SET  = 4'd4,
    RI_DIR_CLR  = 4'd5,
    RI_MODE_SET = 4'd6,
    RI_MODE_CLR = 4'd7,
    RI_POL_SET  = 4'd8,
    RI_POL_CLR  = 4'd9,
    RI_BOTH_SET = 4'd10,
    RI_BOTH_CLR = 4'd11,
    RI_IEN_SET  = 4'd12,
    RI_IEN_CLR  = 4'd13,
    RI_IRQ      = 4'd14,
    RI_NONE     = 4'd15
  } reg_idx_e;

  // Control fields held in set/clear pairs; field k sits at words 2+2k and 3+2k.
  localparam int CT_OUT   = 0;
  localparam int CT_DIR   = 1;
  localparam int CT_MODE  = 2;
  localparam int CT_POL   = 3;
  localparam int CT_BOTH  = 4;
  localparam int CT_IEN   = 5;
  localparam int NUM_CTRL = 6;
  localparam int FIRST_PAIR_WORD = 2;

endpackage

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);
  // Only one of set_we / clr_we can be high, since they decode distinct words.
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (set_we)
      q <= q | mask;
    else if (clr_we)
      q <= q & ~mask;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst)
      stage_q[0] <= '0;
    else
      stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage_q[s] <= '0;
      else
        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_sync,
  input  logic [WIDTH-1:0] edge_mode,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] both_edges,
  input  logic [WIDTH-1:0] enable,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] pending,
  output logic [WIDTH-1:0] active
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)
      prev_q <= '0;
    else
      prev_q <= line_sync;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic rise;
    logic fall;
    logic hit;
    logic drop;

    always_comb begin
      rise = line_sync[i] & ~prev_q[i];
      fall = ~line_sync[i] & prev_q[i];
      if (both_edges[i])
        hit = rise | fall;
      else if (polarity[i])
        hit = rise;
      else
        hit = fall;
      hit  = hit & edge_mode[i] & enable[i];
      drop = clr_we & clr_mask[i];
    end

    // A fresh edge outranks a clear landing in the same cycle.
    always_ff @(posedge clk) begin
      if (rst)
        pending[i] <= 1'b0;
      else if (hit)
        pending[i] <= 1'b1;
      else if (drop)
        pending[i] <= 1'b0;
    end

    always_comb begin
      if (edge_mode[i])
        active[i] = enable[i] & pending[i];
      else
        active[i] = enable[i] & (line_sync[i] ~^ polarity[i]);
    end
  end
endmodule

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq
  import gpio_apb_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq_out
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(RI_IRQ);

  logic [WORD_W-1:0]    word;
  reg_idx_e             idx;
  logic                 wr_en;
  logic                 rd_setup;
  logic [NUM_LINES-1:0] wmask;
  logic [NUM_LINES-1:0] ctrl_q [NUM_CTRL];
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] pend_vec;
  logic [NUM_LINES-1:0] active_vec;
  logic [NUM_LINES-1:0] ien_vec;
  logic                 irq_clr_we;
  logic [BUS_W-1:0]     rd_mux;
  logic                 unused_addr_lsb;

  assign unused_addr_lsb = ^paddr[1:0];

  // Address decode
  assign word = paddr[ADDR_W-1:2];
  always_comb begin
    if (word <= LAST_WORD)
      idx = reg_idx_e'(word[3:0]);
    else
      idx = RI_NONE;
  end

  assign wr_en      = psel & penable & pwrite;
  assign rd_setup   = psel & ~penable & ~pwrite;
  assign wmask      = pwdata[NUM_LINES-1:0];
  assign irq_clr_we = wr_en & (idx == RI_IRQ);

  // Set/clear control fields
  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    localparam reg_idx_e SET_IDX = reg_idx_e'(4'(FIRST_PAIR_WORD + 2 * k));
    localparam reg_idx_e CLR_IDX = reg_idx_e'(4'(FIRST_PAIR_WORD + 2 * k + 1));
    gpio_sc_bank #(.WIDTH(NUM_LINES)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (wr_en & (idx == SET_IDX)),
      .clr_we (wr_en & (idx == CLR_IDX)),
      .mask   (wmask),
      .q      (ctrl_q[k])
    );
  end

  assign ien_vec = ctrl_q[CT_IEN];
  assign pin_out = ctrl_q[CT_OUT];
  assign pin_oe  = ctrl_q[CT_DIR];

  gpio_in_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (line_sync)
  );

  gpio_irq_unit #(.WIDTH(NUM_LINES)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .line_sync  (line_sync),
    .edge_mode  (ctrl_q[CT_MODE]),
    .polarity   (ctrl_q[CT_POL]),
    .both_edges (ctrl_q[CT_BOTH]),
    .enable     (ien_vec),
    .clr_we     (irq_clr_we),
    .clr_mask   (wmask),
    .pending    (pend_vec),
    .active     (active_vec)
  );

  // Read path: chosen in the setup phase, held through the access phase.
  always_comb begin
    rd_mux = '0;
    case (idx)
      RI_PIN_IN:  rd_mux[NUM_LINES-1:0] = line_sync;
      RI_OUT_VAL: rd_mux[NUM_LINES-1:0] = ctrl_q[CT_OUT];
      RI_IRQ:     rd_mux[NUM_LINES-1:0] = active_vec;
      RI_NONE:    rd_mux = '0;
      default:    rd_mux[NUM_LINES-1:0] = ctrl_q[(int'(idx) - FIRST_PAIR_WORD) / 2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      prdata <= '0;
    else if (rd_setup)
      prdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_out <= 1'b0;
    else
      irq_out <= |active_vec;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/gpio_apb_irq_chk.sv
module gpio_apb_irq_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]   pwdata,
  input logic [N-1:0]  pin_in,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq_out,
  input logic [N-1:0]  ien_vec,
  input logic [N-1:0]  pend_vec,
  input logic [N-1:0]  line_sync
);
  logic         wr;
  logic [N-1:0] clr_mask;
  logic [1:0]   age;

  assign wr       = psel & penable & pwrite;
  assign clr_mask = (wr && paddr == ADDR_W'(32'h38)) ? pwdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)
      age <= '0;
    else if (age != 2'd3)
      age <= age + 2'd1;
  end

  a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == ADDR_W'(32'h08)) |=> pin_out == ($past(pin_out) | $past(pwdata[N-1:0])));

  a_r2_out_clr: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == ADDR_W'(32'h0C)) |=> pin_out == ($past(pin_out) & ~$past(pwdata[N-1:0])));

  a_r1_dir_clr: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == ADDR_W'(32'h14)) |=> pin_oe == ($past(pin_oe) & ~$past(pwdata[N-1:0])));

  a_r3_two_stage: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> line_sync == $past(pin_in, 2));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|ien_vec));

  a_r9_pending_held: assert property (@(posedge clk) disable iff (rst)
    ((pend_vec & ~clr_mask) != '0) |=>
      ((pend_vec & $past(pend_vec & ~clr_mask)) == $past(pend_vec & ~clr_mask)));
endmodule

bind gpio_apb_irq gpio_apb_irq_chk #(.N(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .ien_vec   (ien_vec),
  .pend_vec  (pend_vec),
  .line_sync (line_sync)
);

// File: tb/gpio_apb_irq_tb_top.sv
module gpio_apb_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int AW = 8;

  localparam logic [7:0] A_IN   = 8'h00, A_OUT  = 8'h04, A_OSET = 8'h08, A_OCLR = 8'h0C;
  localparam logic [7:0] A_DSET = 8'h10, A_DCLR = 8'h14, A_MSET = 8'h18, A_MCLR = 8'h1C;
  localparam logic [7:0] A_PSET = 8'h20, A_PCLR = 8'h24, A_BSET = 8'h28, A_BCLR = 8'h2C;
  localparam logic [7:0] A_ESET = 8'h30, A_ECLR = 8'h34, A_IRQ  = 8'h38;

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] expv;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'd2, A_OSET, 32'h0000_00F0, A_OUT,  32'h0000_00F0}, // R2 set
    '{8'd2, A_OCLR, 32'h0000_0030, A_OUT,  32'h0000_00C0}, // R2 clear
    '{8'd2, A_OCLR, 32'h0000_0000, A_OUT,  32'h0000_00C0}, // R2 zero bits
    '{8'd1, A_DSET, 32'hFF00_0000, A_DSET, 32'hFF00_0000}, // R1 set
    '{8'd1, A_DCLR, 32'h0F00_0000, A_DCLR, 32'hF000_0000}, // R1 clear
    '{8'd4, A_MSET, 32'h0000_000A, A_MSET, 32'h0000_000A}, // R4 edge
    '{8'd4, A_MCLR, 32'h0000_0002, A_MCLR, 32'h0000_0008}, // R4 level
    '{8'd5, A_PSET, 32'h0000_0005, A_PSET, 32'h0000_0005}, // R5 set
    '{8'd5, A_PCLR, 32'h0000_0004, A_PCLR, 32'h0000_0001}, // R5 clear
    '{8'd6, A_BSET, 32'h0000_0003, A_BSET, 32'h0000_0003}, // R6 set
    '{8'd6, A_BCLR, 32'h0000_0001, A_BCLR, 32'h0000_0002}, // R6 clear
    '{8'd7, A_ESET, 32'h0000_0006, A_ESET, 32'h0000_0006}, // R7 set
    '{8'd7, A_ECLR, 32'h0000_0002, A_ECLR, 32'h0000_0004}  // R7 clear
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_apb_irq #(.NUM_LINES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    if (pready !== 1'b1 || pslverr !== 1'b0) begin
      checks++; errors++;
      $display("FAIL R12 pready/pslverr actual=%b%b expected=10", pready, pslverr);
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic clean_all();
    apb_wr(A_ECLR, '1);
    apb_wr(A_MCLR, '1);
    apb_wr(A_PCLR, '1);
    apb_wr(A_BCLR, '1);
    pin_in = '0;
    idle(4);
    apb_wr(A_IRQ, '1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R12 reset state
    check("R12 pin_oe after reset", 32'(pin_oe), 32'h0);
    check("R12 pin_out after reset", 32'(pin_out), 32'h0);
    check("R12 irq_out after reset", 32'(irq_out), 32'h0);
    apb_rd(A_DSET, rd); check("R12 direction field", rd, 32'h0);
    apb_rd(A_ESET, rd); check("R12 enable field", rd, 32'h0);
    apb_rd(A_MSET, rd); check("R12 mode field", rd, 32'h0);
    apb_rd(A_IRQ, rd);  check("R12 status", rd, 32'h0);

    // Table walk: set/clear pairs for every field
    for (int v = 0; v < NVEC; v++) begin
      apb_wr(VECS[v].waddr, VECS[v].wdata);
      apb_rd(VECS[v].raddr, rd);
      check($sformatf("R%0d table entry %0d", VECS[v].req, v), rd, VECS[v].expv);
    end
    check("R2 pin_out port", 32'(pin_out), 32'h0000_00C0);
    check("R1 pin_oe port", 32'(pin_oe), 32'hF000_0000);
    apb_wr(A_OCLR, '1);
    apb_wr(A_DCLR, '1);
    check("R2 pin_out cleared", 32'(pin_out), 32'h0);
    clean_all();

    // R3 synchronised input read-back
    pin_in = 32'h1234_5678;
    idle(3);
    apb_rd(A_IN, rd); check("R3 input read-back", rd, 32'h1234_5678);
    pin_in = '0;
    idle(3);

    // R8 level high on line 0
    apb_wr(A_PSET, 32'h1);
    apb_wr(A_ESET, 32'h1);
    idle(4);
    check("R8 level not matching irq", 32'(irq_out), 32'h0);
    pin_in[0] = 1'b1;
    idle(4);
    check("R8 level match irq", 32'(irq_out), 32'h1);
    apb_rd(A_IRQ, rd); check("R10 status level", rd, 32'h1);
    apb_wr(A_IRQ, 32'h1);
    idle(2);
    apb_rd(A_IRQ, rd); check("R8 clear has no lasting effect", rd, 32'h1);
    check("R8 irq after clear write", 32'(irq_out), 32'h1);
    pin_in[0] = 1'b0;
    idle(4);
    check("R8 level released", 32'(irq_out), 32'h0);
    // R5 low level
    apb_wr(A_PCLR, 32'h1);
    idle(3);
    check("R5 low level match", 32'(irq_out), 32'h1);
    // R7 disable removes it
    apb_wr(A_ECLR, 32'h1);
    idle(3);
    check("R7 disabled level irq", 32'(irq_out), 32'h0);
    apb_rd(A_IRQ, rd); check("R7 disabled status", rd, 32'h0);
    clean_all();

    // R9 rising edge on line 1
    apb_wr(A_MSET, 32'h2);
    apb_wr(A_PSET, 32'h2);
    apb_wr(A_ESET, 32'h2);
    pin_in[1] = 1'b1;
    idle(5);
    apb_rd(A_IRQ, rd); check("R9 rise latched", rd, 32'h2);
    check("R10 irq on pending", 32'(irq_out), 32'h1);
    pin_in[1] = 1'b0;
    idle(5);
    apb_rd(A_IRQ, rd); check("R9 stays pending after pin returns", rd, 32'h2);
    apb_wr(A_IRQ, 32'h2);
    idle(2);
    apb_rd(A_IRQ, rd); check("R9 cleared by write", rd, 32'h0);
    check("R10 irq after clear", 32'(irq_out), 32'h0);

    // R5 falling edge on line 1
    apb_wr(A_PCLR, 32'h2);
    pin_in[1] = 1'b1;
    idle(5);
    apb_rd(A_IRQ, rd); check("R5 rise ignored with polarity 0", rd, 32'h0);
    pin_in[1] = 1'b0;
    idle(5);
    apb_rd(A_IRQ, rd); check("R5 fall latched", rd, 32'h2);
    apb_wr(A_IRQ, 32'h2);
    clean_all();

    // R6 both edges on line 2
    apb_wr(A_MSET, 32'h4);
    apb_wr(A_BSET, 32'h4);
    apb_wr(A_ESET, 32'h4);
    pin_in[2] = 1'b1;
    idle(5);
    apb_rd(A_IRQ, rd); check("R6 rise latched", rd, 32'h4);
    apb_wr(A_IRQ, 32'h4);
    pin_in[2] = 1'b0;
    idle(5);
    apb_rd(A_IRQ, rd); check("R6 fall latched", rd, 32'h4);
    apb_wr(A_IRQ, 32'h4);
    clean_all();

    // R7 disabled edge line never latches
    apb_wr(A_MSET, 32'h8);
    apb_wr(A_PSET, 32'h8);
    pin_in[3] = 1'b1;
    idle(5);
    check("R7 disabled edge irq", 32'(irq_out), 32'h0);
    apb_wr(A_ESET, 32'h8);
    idle(2);
    apb_rd(A_IRQ, rd); check("R7 no stale pending after enable", rd, 32'h0);
    clean_all();

    // R11 edge coinciding with a clear write
    apb_wr(A_MSET, 32'h6);
    apb_wr(A_PSET, 32'h2);
    apb_wr(A_BSET, 32'h4);
    apb_wr(A_ESET, 32'h6);
    pin_in[2] = 1'b1;
    idle(5);
    apb_rd(A_IRQ, rd); check("R11 setup line 2 pending", rd, 32'h4);
    @(negedge clk);
    pin_in[1] = 1'b1;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = A_IRQ; pwdata = 32'h6;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    idle(2);
    apb_rd(A_IRQ, rd); check("R11 edge wins over clear", rd, 32'h2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule